// File: doc/BRIEF.md
# Advanced Load Alias Table

This block lets a load that was scheduled ahead of stores with unknown addresses run early and be confirmed afterwards. When the early (advanced) load issues, the table records its destination register and the word address it read. Every later store presents its address on a snoop port, and any tracked entry whose word matches is dropped. When the program reaches the point where the load originally stood, a check names the register. The table then reports one of three verdicts: nothing to do, reissue the load, or branch to a recovery routine.

Two kinds of check exist. A load-check repairs only the loaded value, so on a conflict it asks for the load to be reissued. An advanced-check also covers instructions that already used the early value, so on a conflict it returns the supplied recovery target as a branch. Each check retires its entry. A register that is not tracked, because it was never loaded early, was evicted to make room, or was already checked, always counts as a conflict. This keeps the verdict safe.

The table is fully associative with a small fixed number of slots, and each slot tracks at most one destination register. When every slot is in use, a new register takes the slot that was filled longest ago. Within one cycle the events are ordered as store first, then check, then advanced load.

Top module: `alat_top`

## Requirements
- R1: After reset no register is tracked and `rsp_valid` is low.
- R2: A check presented in cycle t gives `rsp_valid` high in cycle t+1 only. If the register is tracked and no matching store came after its advanced load, the verdict is no-op (`rsp_action` = 0) with `rsp_target` = 0.
- R3: A load-check (`chk_kind` = 0) of a register whose entry was cleared by a store gives reissue (`rsp_action` = 1) with `rsp_target` = 0. Stores match on the word address, so address bits [1:0] are ignored.
- R4: An advanced-check (`chk_kind` = 1) that finds a conflict gives branch (`rsp_action` = 2) with `rsp_target` equal to the `chk_target` it was given.
- R5: An advanced-check that finds no conflict gives no-op with `rsp_target` = 0.
- R6: A store to a different word leaves the entry tracked.
- R7: One store clears every tracked entry whose word matches, all in the same cycle.
- R8: A second advanced load to a register that is already tracked replaces the recorded address. Stores to the old address then have no effect on it, and stores to the new address do.
- R9: With every slot in use, an advanced load for a new register evicts the entry inserted earliest. A later check of the evicted register reports a conflict, while the other entries stay tracked.
- R10: Checking a register that was never loaded early reports a conflict.
- R11: A check retires its entry, so a second check of the same register, with no new advanced load in between, reports a conflict.
- R12: A store and an advanced load to the same word in the same cycle leave the register tracked.
- R13: A store that matches in the same cycle as a check of that register makes that check report a conflict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_valid | input | 1 | Advanced load issues this cycle |
| ld_reg | input | REG_W | Destination register of the advanced load |
| ld_addr | input | ADDR_W | Byte address read by the advanced load |
| st_valid | input | 1 | Store snoop valid |
| st_addr | input | ADDR_W | Byte address of the store |
| chk_valid | input | 1 | Check issues this cycle |
| chk_reg | input | REG_W | Register being checked |
| chk_kind | input | 1 | 0 = load-check, 1 = advanced-check |
| chk_target | input | TGT_W | Recovery target for an advanced-check |
| rsp_valid | output | 1 | Verdict valid (one cycle after the check) |
| rsp_action | output | 2 | 0 = no-op, 1 = reissue load, 2 = branch |
| rsp_target | output | TGT_W | Recovery target when branching, else 0 |

## Verification
Corrupted table state is visible only through verdicts, and only one cycle after a check of the affected register. A slot that stays valid after a matching store would turn a required reissue or branch into a silent no-op. That is the dangerous direction, and the bench targets it with same-word stores that use different byte offsets and with one store that hits several entries. A wrong insertion order shows up only when the table is full, so the bench fills every slot before it adds one more register. It then checks the oldest register, which must conflict, and the remaining registers, which must all report no-op.

// File: rtl/alat_pkg.sv
package alat_pkg;

    typedef enum logic [1:0] {
        ACT_NOP    = 2'd0,
        ACT_RELOAD = 2'd1,
        ACT_BRANCH = 2'd2
    } alat_act_e;

    localparam logic KIND_LOAD_CHECK = 1'b0;
    localparam logic KIND_ADV_CHECK  = 1'b1;

    function automatic alat_act_e verdict(input logic clean, input logic kind);
        if (clean)
            return ACT_NOP;
        else if (kind == KIND_ADV_CHECK)
            return ACT_BRANCH;
        else
            return ACT_RELOAD;
    endfunction

endpackage

// File: rtl/alat_cam.sv
module alat_cam #(
    parameter int ENTRIES = 16,
    parameter int REG_W   = 7,
    parameter int WORD_W  = 30
) (
    input  logic [ENTRIES-1:0]             ent_valid,
    input  logic [ENTRIES-1:0][REG_W-1:0]  ent_reg,
    input  logic [ENTRIES-1:0][WORD_W-1:0] ent_word,
    input  logic [REG_W-1:0]               ld_reg,
    input  logic [REG_W-1:0]               chk_reg,
    input  logic                           st_valid,
    input  logic [WORD_W-1:0]              st_word,
    output logic [ENTRIES-1:0]             ld_hit,
    output logic [ENTRIES-1:0]             chk_hit,
    output logic [ENTRIES-1:0]             st_hit
);
    for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
        assign ld_hit[i]  = ent_valid[i] && (ent_reg[i] == ld_reg);
        assign chk_hit[i] = ent_valid[i] && (ent_reg[i] == chk_reg);
        assign st_hit[i]  = st_valid && ent_valid[i] && (ent_word[i] == st_word);
    end
endmodule

// File: rtl/alat_order.sv
module alat_order #(
    parameter int ENTRIES = 16,
    localparam int IW = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ins_en,
    input  logic [IW-1:0]      ins_idx,
    input  logic [ENTRIES-1:0] ent_valid,
    output logic [IW-1:0]      victim_idx
);
    // older[a][b] set: slot a was filled before slot b
    logic [ENTRIES-1:0][ENTRIES-1:0] older;
    logic [ENTRIES-1:0]              is_oldest;

    always_ff @(posedge clk) begin
        if (rst) begin
            older <= '0;
        end else if (ins_en) begin
            for (int j = 0; j < ENTRIES; j++) begin
                if (j != int'(ins_idx)) begin
                    older[j][ins_idx] <= 1'b1;
                    older[ins_idx][j] <= 1'b0;
                end
            end
        end
    end

    for (genvar i = 0; i < ENTRIES; i++) begin : g_age
        logic [ENTRIES-1:0] self_bit;
        assign self_bit     = ENTRIES'(1) << i;
        assign is_oldest[i] = ent_valid[i] && (&(older[i] | ~ent_valid | self_bit));
    end

    always_comb begin
        victim_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (is_oldest[i]) victim_idx = IW'(i);
        end
    end
endmodule

// File: rtl/alat_resolve.sv
module alat_resolve
    import alat_pkg::*;
#(
    parameter int TGT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             chk_valid,
    input  logic             chk_kind,
    input  logic             chk_clean,
    input  logic [TGT_W-1:0] chk_target,
    output logic             rsp_valid,
    output logic [1:0]       rsp_action,
    output logic [TGT_W-1:0] rsp_target
);
    alat_act_e act_q;
    alat_act_e act_d;

    assign act_d = verdict(chk_clean, chk_kind);

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid  <= 1'b0;
            act_q      <= ACT_NOP;
            rsp_target <= '0;
        end else begin
            rsp_valid  <= chk_valid;
            act_q      <= chk_valid ? act_d : ACT_NOP;
            rsp_target <= (chk_valid && act_d == ACT_BRANCH) ? chk_target : '0;
        end
    end

    assign rsp_action = act_q;
endmodule

// File: rtl/alat_top.sv
module alat_top
    import alat_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int REG_W   = 7,
    parameter int ADDR_W  = 32,
    parameter int OFF_W   = 2,
    parameter int TGT_W   = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_valid,
    input  logic [REG_W-1:0]  ld_reg,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic              st_valid,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic              chk_valid,
    input  logic [REG_W-1:0]  chk_reg,
    input  logic              chk_kind,
    input  logic [TGT_W-1:0]  chk_target,
    output logic              rsp_valid,
    output logic [1:0]        rsp_action,
    output logic [TGT_W-1:0]  rsp_target
);
    localparam int IW     = $clog2(ENTRIES);
    localparam int WORD_W = ADDR_W - OFF_W;

    logic [ENTRIES-1:0]             ent_valid;
    logic [ENTRIES-1:0][REG_W-1:0]  ent_reg;
    logic [ENTRIES-1:0][WORD_W-1:0] ent_word;

    logic [WORD_W-1:0]  ld_word, st_word;
    logic               unused_offset_bits;
    logic [ENTRIES-1:0] ld_hit, chk_hit, st_hit, kill;
    logic [IW-1:0]      ld_idx, free_idx, victim_idx, ins_idx;
    logic               ld_found, free_found, chk_clean;

    assign ld_word            = ld_addr[ADDR_W-1:OFF_W];
    assign st_word            = st_addr[ADDR_W-1:OFF_W];
    assign unused_offset_bits = ^{ld_addr[OFF_W-1:0], st_addr[OFF_W-1:0]};

    alat_cam #(.ENTRIES(ENTRIES), .REG_W(REG_W), .WORD_W(WORD_W)) u_cam (
        .ent_valid (ent_valid),
        .ent_reg   (ent_reg),
        .ent_word  (ent_word),
        .ld_reg    (ld_reg),
        .chk_reg   (chk_reg),
        .st_valid  (st_valid),
        .st_word   (st_word),
        .ld_hit    (ld_hit),
        .chk_hit   (chk_hit),
        .st_hit    (st_hit)
    );

    alat_order #(.ENTRIES(ENTRIES)) u_order (
        .clk        (clk),
        .rst        (rst),
        .ins_en     (ld_valid),
        .ins_idx    (ins_idx),
        .ent_valid  (ent_valid),
        .victim_idx (victim_idx)
    );

    // slot choice: same register, else lowest free slot, else oldest
    always_comb begin
        ld_idx     = '0;
        ld_found   = 1'b0;
        free_idx   = '0;
        free_found = 1'b0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (ld_hit[i]) begin
                ld_idx   = IW'(i);
                ld_found = 1'b1;
            end
            if (!ent_valid[i]) begin
                free_idx   = IW'(i);
                free_found = 1'b1;
            end
        end
        if (ld_found)
            ins_idx = ld_idx;
        else if (free_found)
            ins_idx = free_idx;
        else
            ins_idx = victim_idx;
    end

    // within a cycle: store, then check, then advanced load
    assign kill      = st_hit | (chk_valid ? chk_hit : '0);
    assign chk_clean = chk_valid && (|(chk_hit & ~st_hit));

    always_ff @(posedge clk) begin
        if (rst) begin
            ent_valid <= '0;
            ent_reg   <= '0;
            ent_word  <= '0;
        end else begin
            ent_valid <= ent_valid & ~kill;
            if (ld_valid) begin
                ent_valid[ins_idx] <= 1'b1;
                ent_reg[ins_idx]   <= ld_reg;
                ent_word[ins_idx]  <= ld_word;
            end
        end
    end

    alat_resolve #(.TGT_W(TGT_W)) u_resolve (
        .clk        (clk),
        .rst        (rst),
        .chk_valid  (chk_valid),
        .chk_kind   (chk_kind),
        .chk_clean  (chk_clean),
        .chk_target (chk_target),
        .rsp_valid  (rsp_valid),
        .rsp_action (rsp_action),
        .rsp_target (rsp_target)
    );
endmodule

// File: rtl/alat_chk.sv
module alat_chk #(
    parameter int ENTRIES = 16,
    parameter int REG_W   = 7,
    parameter int ADDR_W  = 32,
    parameter int OFF_W   = 2,
    parameter int TGT_W   = 16,
    localparam int WORD_W = ADDR_W - OFF_W
) (
    input logic                           clk,
    input logic                           rst,
    input logic                           ld_valid,
    input logic                           st_valid,
    input logic [ADDR_W-1:0]              st_addr,
    input logic                           chk_valid,
    input logic [REG_W-1:0]               chk_reg,
    input logic                           chk_kind,
    input logic [TGT_W-1:0]               chk_target,
    input logic                           rsp_valid,
    input logic [1:0]                     rsp_action,
    input logic [TGT_W-1:0]               rsp_target,
    input logic [ENTRIES-1:0]             ent_valid,
    input logic [ENTRIES-1:0][REG_W-1:0]  ent_reg,
    input logic [ENTRIES-1:0][WORD_W-1:0] ent_word
);
    p_rsp_follows_chk_r2: assert property (@(posedge clk) disable iff (rst)
        chk_valid |=> rsp_valid);

    p_no_rsp_without_chk_r2: assert property (@(posedge clk) disable iff (rst)
        !chk_valid |=> !rsp_valid);

    p_action_legal_r2: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> rsp_action != 2'd3);

    p_nop_no_target_r5: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_action == 2'd0) |-> rsp_target == '0);

    p_reload_kind_r3: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_action == 2'd1) |-> ($past(chk_kind) == 1'b0 && rsp_target == '0));

    p_branch_target_r4: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_action == 2'd2) |->
            ($past(chk_kind) == 1'b1 && rsp_target == $past(chk_target)));

    p_load_tracked_r8: assert property (@(posedge clk) disable iff (rst)
        ld_valid |=> ent_valid != '0);

    for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
        p_store_clears_r7: assert property (@(posedge clk) disable iff (rst)
            (st_valid && !ld_valid && ent_valid[i] &&
             ent_word[i] == st_addr[ADDR_W-1:OFF_W]) |=> !ent_valid[i]);

        p_check_retires_r11: assert property (@(posedge clk) disable iff (rst)
            (chk_valid && !ld_valid && ent_valid[i] && ent_reg[i] == chk_reg)
                |=> !ent_valid[i]);
    end
endmodule

bind alat_top alat_chk #(
    .ENTRIES(ENTRIES), .REG_W(REG_W), .ADDR_W(ADDR_W), .OFF_W(OFF_W), .TGT_W(TGT_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ld_valid   (ld_valid),
    .st_valid   (st_valid),
    .st_addr    (st_addr),
    .chk_valid  (chk_valid),
    .chk_reg    (chk_reg),
    .chk_kind   (chk_kind),
    .chk_target (chk_target),
    .rsp_valid  (rsp_valid),
    .rsp_action (rsp_action),
    .rsp_target (rsp_target),
    .ent_valid  (ent_valid),
    .ent_reg    (ent_reg),
    .ent_word   (ent_word)
);

// File: tb/sim_alat_top.sv
module sim_alat_top;
    localparam int ENTRIES = 16;
    localparam int REG_W   = 7;
    localparam int ADDR_W  = 32;
    localparam int TGT_W   = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              ld_valid = 1'b0;
    logic [REG_W-1:0]  ld_reg = '0;
    logic [ADDR_W-1:0] ld_addr = '0;
    logic              st_valid = 1'b0;
    logic [ADDR_W-1:0] st_addr = '0;
    logic              chk_valid = 1'b0;
    logic [REG_W-1:0]  chk_reg = '0;
    logic              chk_kind = 1'b0;
    logic [TGT_W-1:0]  chk_target = '0;
    logic              rsp_valid;
    logic [1:0]        rsp_action;
    logic [TGT_W-1:0]  rsp_target;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic [1:0]       q_act[$];
    logic [TGT_W-1:0] q_tgt[$];
    string            q_req[$];

    always #10 clk = ~clk;

    alat_top #(.ENTRIES(ENTRIES), .REG_W(REG_W), .ADDR_W(ADDR_W), .TGT_W(TGT_W)) u0 (
        .clk(clk), .rst(rst),
        .ld_valid(ld_valid), .ld_reg(ld_reg), .ld_addr(ld_addr),
        .st_valid(st_valid), .st_addr(st_addr),
        .chk_valid(chk_valid), .chk_reg(chk_reg), .chk_kind(chk_kind), .chk_target(chk_target),
        .rsp_valid(rsp_valid), .rsp_action(rsp_action), .rsp_target(rsp_target)
    );

    // Monitor: outputs are sampled on the falling edge
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            total++;
            if (q_act.size() == 0) begin
                bad++;
                $display("FAIL R2: unexpected response act=%0d tgt=%0h expected none",
                         rsp_action, rsp_target);
            end else begin
                logic [1:0]       ea;
                logic [TGT_W-1:0] et;
                string            er;
                ea = q_act.pop_front();
                et = q_tgt.pop_front();
                er = q_req.pop_front();
                if (rsp_action !== ea || rsp_target !== et) begin
                    bad++;
                    $display("FAIL %s: act=%0d tgt=%0h expected act=%0d tgt=%0h",
                             er, rsp_action, rsp_target, ea, et);
                end
            end
        end
    end

    // Driver: one cycle of stimulus, started and ended on a falling edge
    task automatic cyc(input bit lv, input int lr, input int la,
                       input bit sv, input int sa,
                       input bit cv, input int cr, input bit ck, input int ct);
        ld_valid   = lv;  ld_reg  = REG_W'(lr); ld_addr = ADDR_W'(la);
        st_valid   = sv;  st_addr = ADDR_W'(sa);
        chk_valid  = cv;  chk_reg = REG_W'(cr); chk_kind = ck; chk_target = TGT_W'(ct);
        @(negedge clk);
        ld_valid = 1'b0; st_valid = 1'b0; chk_valid = 1'b0;
    endtask

    task automatic load(input int r, input int a);
        cyc(1, r, a, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic store(input int a);
        cyc(0, 0, 0, 1, a, 0, 0, 0, 0);
    endtask

    task automatic expect_rsp(input logic [1:0] a, input int t, input string req);
        q_act.push_back(a);
        q_tgt.push_back(TGT_W'(t));
        q_req.push_back(req);
    endtask

    task automatic check(input int r, input bit k, input int t,
                         input logic [1:0] ea, input int et, input string req);
        expect_rsp(ea, et, req);
        cyc(0, 0, 0, 0, 0, 1, r, k, t);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: act=timeout expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        total++;
        if (rsp_valid !== 1'b0) begin
            bad++;
            $display("FAIL R1: rsp_valid=%0b expected 0", rsp_valid);
        end

        // R10: never-loaded registers conflict
        check(5, 0, 0,     2'd1, 0,     "R10");
        check(6, 1, 'h123, 2'd2, 'h123, "R10");

        // R2: tracked, no store -> no-op
        load(1, 'h100);
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0);
        check(1, 0, 0, 2'd0, 0, "R2");

        // R3: same word, different byte offset -> reissue
        load(2, 'h200);
        store('h203);
        check(2, 0, 'h77, 2'd1, 0, "R3");

        // R6 and R5: other word leaves it tracked; clean advanced-check
        load(3, 'h300);
        store('h304);
        check(3, 1, 'h55, 2'd0, 0, "R6/R5");

        // R4: advanced-check with conflict -> branch with target
        load(4, 'h400);
        store('h400);
        check(4, 1, 'hBEEF, 2'd2, 'hBEEF, "R4");

        // R7: one store clears several entries
        load(7, 'h500);
        load(8, 'h500);
        load(9, 'h502);
        load(10, 'h504);
        store('h501);
        check(7, 0, 0, 2'd1, 0, "R7");
        check(8, 0, 0, 2'd1, 0, "R7");
        check(9, 0, 0, 2'd1, 0, "R7");
        check(10, 0, 0, 2'd0, 0, "R7");

        // R8: reload same register replaces address
        load(11, 'h600);
        load(11, 'h700);
        store('h600);
        check(11, 0, 0, 2'd0, 0, "R8");
        load(12, 'h800);
        load(12, 'h900);
        store('h900);
        check(12, 0, 0, 2'd1, 0, "R8");

        // R11: check retires its entry
        load(13, 'hA00);
        check(13, 0, 0, 2'd0, 0, "R11");
        check(13, 0, 0, 2'd1, 0, "R11");

        // R12: store and load to same word in one cycle
        cyc(1, 14, 'hB00, 1, 'hB00, 0, 0, 0, 0);
        check(14, 0, 0, 2'd0, 0, "R12");

        // R13: store and check in one cycle
        load(15, 'hC00);
        expect_rsp(2'd2, 7, "R13");
        cyc(0, 0, 0, 1, 'hC02, 1, 15, 1, 7);

        // R9: fill all slots, one more evicts the first inserted
        for (int i = 0; i < ENTRIES; i++) load(20 + i, 'h1000 + 16 * i);
        load(40, 'h2000);
        check(20, 0, 0, 2'd1, 0, "R9");
        for (int i = 1; i < ENTRIES; i++) check(20 + i, 0, 0, 2'd0, 0, "R9");
        check(40, 1, 'h99, 2'd0, 0, "R9");

        repeat (4) @(negedge clk);
        total++;
        if (q_act.size() != 0) begin
            bad++;
            $display("FAIL R2: pending=%0d expected 0", q_act.size());
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule